// File: doc/BRIEF.md
# System Control Register Bank

This block is a word-addressed slave register bank for a platform controller. It decodes a 4 KiB byte window. The lower half of the window is backed by 512 general-purpose 32-bit words that software can read and write. The upper half is decoded but holds no storage. Four words come out of reset with nonzero preset values. Three locations return their stored contents with two status bits forced high on every read.

One location in the unbacked half acts as a command port. Writing a reset code to it produces a one-cycle system-reset request. Writing the power-off code produces a one-cycle shutdown request. The reset and power controllers downstream consume these pulses.

The bank accepts one request per cycle on a valid/ready register bus. The bus has separate address, write data and read data lanes. Read data is registered and arrives one cycle after acceptance. Writes return no response.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, and every other backed word holds zero.
- R2: An accepted write to a byte offset below 0x800 stores all 32 data bits at word index offset/4, and a later read of that offset returns them.
- R3: The two low address bits are ignored, so offsets that differ only in bits 1:0 reach the same word.
- R4: A write to a byte offset at or above 0x800 changes no stored word, and it does not alias onto a low word. A read from such an offset returns zero.
- R5: Reads from byte offsets 0x100, 0x108 and 0x10C return the stored word OR 0x30000000 (bits 29 and 28 set). The stored word itself is left unchanged. Other offsets, such as 0x104, return the stored value unmodified.
- R6: A write of value 1 or 2 to byte offset 0xF00 drives sys_reset_req high for exactly the one cycle that follows acceptance. sys_off_req stays low.
- R7: A write of value 3 to byte offset 0xF00 drives sys_off_req high for exactly the one cycle that follows acceptance. sys_reset_req stays low.
- R8: Any other value written to 0xF00, any read of 0xF00, and any write of a command value to a different offset raise no request. A read of 0xF00 returns zero.
- R9: rsp_valid is high for exactly the one cycle after a read is accepted, with rsp_rdata valid in that cycle. A write never raises rsp_valid.
- R10: req_ready is high whenever the block is out of reset, so every valid request is accepted in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system-reset request |
| sys_off_req | output | 1 | One-cycle shutdown request |

## Verification
The bench writes to offset 0x800 and then reads word 0. A decoder that truncates the word index instead of range-checking it would overwrite word 0 through this alias. The bench also writes zero to a masked location and reads it back. A bank that stored the forced bits, or applied the mask to the neighbouring 0x104, would return the wrong value there. At the command port, the bench sends codes 0, 4 and 0x101, sends code 1 to a plain offset, and reads 0xF00. These catch a decoder that checks only the low bits of the value or ignores the address. The bench also checks that each request pulse falls after one cycle, which catches a level that is held instead of pulsed.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W = 32;

  // Preset contents of the backed words after reset.
  function automatic logic [DATA_W-1:0] preset_value(input int idx);
    logic [DATA_W-1:0] v;
    case (idx)
      'h40:    v = 32'h05F2_0121;
      'h41:    v = 32'h0000_0002;
      'h42:    v = 32'h05F3_0121;
      'h43:    v = 32'h05F4_0121;
      default: v = '0;
    endcase
    return v;
  endfunction

  // Words whose read value carries forced status bits.
  function automatic logic is_forced_word(input int idx);
    return (idx == 'h40) || (idx == 'h42) || (idx == 'h43);
  endfunction

endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int               ADDR_W    = 12,
  parameter int               NUM_WORDS = 512,
  parameter logic [ADDR_W-1:0] CMD_OFF  = 12'hF00,
  localparam int              WORD_W    = ADDR_W - 2,
  localparam int              IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              in_range,
  output logic              is_cmd
);

  logic [WORD_W-1:0] word;

  always_comb begin
    word     = addr[ADDR_W-1:2];
    in_range = ({22'd0, word} < 32'(NUM_WORDS));
    word_idx = word[IDX_W-1:0];
    is_cmd   = (word == CMD_OFF[ADDR_W-1:2]);
  end

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int  NUM_WORDS = 512,
  localparam int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem_q [NUM_WORDS];
  logic [DATA_W-1:0] mem_d [NUM_WORDS];

  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (wr_en) mem_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= preset_value(i);
    end else if (wr_en) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_word = mem_q[rd_idx];

  // R2
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] CODE_RST_A = 32'd1,
  parameter logic [DATA_W-1:0] CODE_RST_B = 32'd2,
  parameter logic [DATA_W-1:0] CODE_OFF   = 32'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic              rst_pulse,
  output logic              off_pulse
);

  logic rst_q, rst_d, off_q, off_d;
  logic cmd_hit;

  always_comb begin
    cmd_hit = wr_fire && is_cmd;
    rst_d   = cmd_hit && ((wdata == CODE_RST_A) || (wdata == CODE_RST_B));
    off_d   = cmd_hit && (wdata == CODE_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      off_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      off_q <= off_d;
    end
  end

  assign rst_pulse = rst_q;
  assign off_pulse = off_q;

  // R6
  cmd_reset_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(wr_fire && is_cmd && (wdata == CODE_RST_A || wdata == CODE_RST_B)));

  // R7
  cmd_off_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_pulse |-> $past(wr_fire && is_cmd && wdata == CODE_OFF));

  // R8
  cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_pulse, off_pulse}));

endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath
  import sysctl_pkg::*;
#(
  parameter int                FORCE_EN   = 1,
  parameter logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000,
  parameter int                NUM_WORDS  = 512,
  localparam int               IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              in_range,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] store_word,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [DATA_W-1:0] shaped;
  logic [DATA_W-1:0] data_d, data_q;
  logic              vld_q;

  generate
    if (FORCE_EN != 0) begin : g_force
      always_comb begin
        shaped = store_word;
        if (is_forced_word(int'(rd_idx))) shaped = store_word | FORCE_MASK;
      end
    end else begin : g_plain
      always_comb shaped = store_word;
    end
  endgenerate

  always_comb begin
    data_d = in_range ? shaped : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= rd_fire;
      if (rd_fire) data_q <= data_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = data_q;

  // R9
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_fire));

  // R4
  rsp_unbacked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !in_range) |=> rsp_rdata == '0);

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                NUM_WORDS  = 512,
  parameter logic [ADDR_W-1:0] CMD_OFF    = 12'hF00,
  parameter logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000,
  localparam int               IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sys_reset_req,
  output logic              sys_off_req
);

  logic             rst_n_int;
  logic [IDX_W-1:0] word_idx;
  logic             in_range, is_cmd;
  logic             fire, wr_fire, rd_fire;
  logic [DATA_W-1:0] store_word;

  sysctl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sysctl_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .CMD_OFF   (CMD_OFF)
  ) u_dec (
    .addr     (req_addr),
    .word_idx (word_idx),
    .in_range (in_range),
    .is_cmd   (is_cmd)
  );

  always_comb begin
    req_ready = rst_n_int;
    fire      = req_valid && req_ready;
    wr_fire   = fire && req_write;
    rd_fire   = fire && !req_write;
  end

  sysctl_store #(.NUM_WORDS(NUM_WORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_fire && in_range),
    .wr_idx  (word_idx),
    .wr_data (req_wdata),
    .rd_idx  (word_idx),
    .rd_word (store_word)
  );

  sysctl_cmd u_cmd (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_fire   (wr_fire),
    .is_cmd    (is_cmd),
    .wdata     (req_wdata),
    .rst_pulse (sys_reset_req),
    .off_pulse (sys_off_req)
  );

  sysctl_rdpath #(
    .FORCE_EN   (1),
    .FORCE_MASK (FORCE_MASK),
    .NUM_WORDS  (NUM_WORDS)
  ) u_rd (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .rd_fire    (rd_fire),
    .in_range   (in_range),
    .rd_idx     (word_idx),
    .store_word (store_word),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // R9
  write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_fire |=> !rsp_valid);

endmodule

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sys_reset_req, sys_off_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  sysctl_regbank uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .sys_reset_req (sys_reset_req), .sys_off_req (sys_off_req)
  );

  logic obs_rst, obs_off, obs_vld;
  logic [31:0] obs_data;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Bus tasks start and end just after a falling edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    obs_rst = sys_reset_req; obs_off = sys_off_req; obs_vld = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    obs_rst = sys_reset_req; obs_off = sys_off_req;
    obs_vld = rsp_valid; obs_data = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string req);
    rd(a);
    check(obs_vld === 1'b1, req, {31'd0, obs_vld}, 32'd1);
    check(obs_data === exp, req, obs_data, exp);
  endtask

  task automatic test_reset_state;
    check(req_ready === 1'b1, "R10", {31'd0, req_ready}, 32'd1);
    check(rsp_valid === 1'b0, "R9", {31'd0, rsp_valid}, 32'd0);
    check(sys_reset_req === 1'b0 && sys_off_req === 1'b0, "R6",
          {30'd0, sys_reset_req, sys_off_req}, 32'd0);
    rd_expect(12'h100, 32'h35F2_0121, "R1");
    rd_expect(12'h104, 32'h0000_0002, "R1");
    rd_expect(12'h108, 32'h35F3_0121, "R1");
    rd_expect(12'h10C, 32'h35F4_0121, "R1");
    rd_expect(12'h000, 32'h0, "R1");
    rd_expect(12'h7FC, 32'h0, "R1");
  endtask

  task automatic test_rw;
    wr(12'h010, 32'hA5A5_5A5A);
    check(obs_vld === 1'b0, "R9", {31'd0, obs_vld}, 32'd0);
    wr(12'h7FC, 32'hDEAD_BEEF);
    rd_expect(12'h010, 32'hA5A5_5A5A, "R2");
    rd_expect(12'h7FC, 32'hDEAD_BEEF, "R2");
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic test_low_bits;
    wr(12'h021, 32'h1234_5678);
    rd_expect(12'h020, 32'h1234_5678, "R3");
    rd_expect(12'h023, 32'h1234_5678, "R3");
  endtask

  task automatic test_unbacked;
    wr(12'h800, 32'hFFFF_FFFF);
    rd_expect(12'h800, 32'h0, "R4");
    rd_expect(12'h000, 32'h0, "R4");
    wr(12'hC10, 32'h0BAD_0BAD);
    rd_expect(12'h010, 32'hA5A5_5A5A, "R4");
  endtask

  task automatic test_force_bits;
    wr(12'h100, 32'h0);
    rd_expect(12'h100, 32'h3000_0000, "R5");
    wr(12'h104, 32'h0000_FFFF);
    rd_expect(12'h104, 32'h0000_FFFF, "R5");
    wr(12'h108, 32'hCFFF_FFFF);
    rd_expect(12'h108, 32'hFFFF_FFFF, "R5");
  endtask

  task automatic cmd_case(input logic [31:0] code, input bit exp_rst, input bit exp_off, input string req);
    wr(12'hF00, code);
    check(obs_rst === exp_rst, req, {31'd0, obs_rst}, {31'd0, exp_rst});
    check(obs_off === exp_off, req, {31'd0, obs_off}, {31'd0, exp_off});
    @(negedge clk);
    check(sys_reset_req === 1'b0 && sys_off_req === 1'b0, req,
          {30'd0, sys_reset_req, sys_off_req}, 32'd0);
  endtask

  task automatic test_commands;
    cmd_case(32'd1, 1'b1, 1'b0, "R6");
    cmd_case(32'd2, 1'b1, 1'b0, "R6");
    cmd_case(32'd3, 1'b0, 1'b1, "R7");
    cmd_case(32'd0, 1'b0, 1'b0, "R8");
    cmd_case(32'd4, 1'b0, 1'b0, "R8");
    cmd_case(32'h101, 1'b0, 1'b0, "R8");
    wr(12'h300, 32'd1);
    check(obs_rst === 1'b0 && obs_off === 1'b0, "R8", {30'd0, obs_rst, obs_off}, 32'd0);
    rd_expect(12'hF00, 32'h0, "R8");
    check(obs_rst === 1'b0 && obs_off === 1'b0, "R8", {30'd0, obs_rst, obs_off}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset_state();
    test_rw();
    test_low_bits();
    test_unbacked();
    test_force_bits();
    test_commands();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule